// File: doc/BRIEF.md
# Sector Buffer Writer with Deferred Header Load

This block takes a stream of raw disc-sector bytes, each tagged with its position inside the sector, and stores them in a ring buffer. A 16-bit write address, loaded one byte at a time, is the storage cursor. The ring depth is a parameter: BUF_AW = 14 gives the full 16 KB ring, and the default of 11 keeps elaboration small. A two-bit control setting picks among three behaviours. With both bits set, bytes are stored in the ring. With only the enable bit set, the block watches the stream and copies the four sector header bytes straight into its header registers. With the enable bit clear, nothing is kept.

The byte at offset 12 follows the 12-byte sync field, so it marks where the header of a new sector begins. When that byte is stored, the block sets a block pointer 2352 bytes back from the cursor, which is the start of the sector just completed. It then starts a decode timer. When the timer expires, the block fetches four bytes from the ring, starting at the pointer, into the header registers. It then marks the headers as valid and pulls its active-low decode flag low. Software can also aim a decode at any pointer by writing the pointer high byte.

Top module: `sector_buf_writer`

## Requirements
- R1: Register writes use `reg_sel` codes 0 = control, 1 = write-address low byte, 2 = write-address high byte, 3 = pointer low byte, 4 = pointer high byte. A byte is stored (`buf_we` = 1) only when control bit 7 (decode enable) and control bit 2 (write request) are both 1. The ring index is the low BUF_AW bits of `wr_addr`.
- R2: Each stored byte advances `wr_addr` by one in the following cycle, and the carry out of the low byte goes into the high byte. A byte that is not stored leaves `wr_addr` unchanged.
- R3: Any valid byte at offset 12 sets `hdr_pend` in the following cycle, in every control setting.
- R4: A stored byte at offset 12 loads `blk_ptr` with the pre-increment `wr_addr` minus 2352 (modulo 2^16), starts a decode, and drives `dec_irq_n` high.
- R5: A decode started at clock edge t completes at edge t+DECODE_LAT+5. At that edge `hdr_pend` goes to 0 and `dec_irq_n` goes to 0. Before that edge both keep their values.
- R6: At completion, `hdr_bytes[8k+7:8k]` holds the ring byte at index (`blk_ptr`+k) mod 2^BUF_AW, for k = 0..3, so the fetch wraps at the end of the ring.
- R7: In monitor mode (control bit 7 = 1, bit 2 = 0), bytes at offsets 12..15 go into header byte (offset−12). No byte is stored and `wr_addr` is unchanged. No decode starts.
- R8: A write to the pointer high byte starts a decode with the same latency, and `dec_irq_n` goes high.
- R9: A decode start that arrives while a decode is pending restarts the countdown from the new start, and the earlier completion never occurs.
- R10: After reset, `wr_addr`, `blk_ptr`, `hdr_bytes` and `hdr_pend` are 0 and `dec_irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 8 | Register write data |
| byte_valid | input | 1 | Sector byte present this cycle |
| byte_ofs | input | OFS_W | Position of the byte inside its sector |
| byte_data | input | 8 | Sector byte |
| buf_we | output | 1 | Ring write enable |
| buf_waddr | output | BUF_AW | Ring write index |
| buf_wdata | output | 8 | Ring write data |
| wr_addr | output | 16 | Write-address register |
| blk_ptr | output | 16 | Block pointer register |
| hdr_bytes | output | 32 | Four header registers, byte 0 in bits 7:0 |
| hdr_pend | output | 1 | Header registers not yet valid |
| dec_irq_n | output | 1 | Active-low decode-complete flag |

## Verification
The store path is driven from a table of control settings, including settings that have only one of the two bits, neither bit, or extra bits set. This shows that both bits gate the store and that the other bits play no part. The decode is started three ways: by a sync byte with a mid-ring pointer, by a pointer write whose four-byte fetch crosses the end of the ring, and by a second sync that lands before the first decode completes. Together these separate the pointer back-computation, the wrapping fetch and the restarted countdown. Monitor mode is sent a full header run, which shows that the header registers load directly while the ring and the cursor stay untouched.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  typedef enum logic [2:0] {
    SEL_CTL    = 3'd0,
    SEL_WA_LO  = 3'd1,
    SEL_WA_HI  = 3'd2,
    SEL_PTR_LO = 3'd3,
    SEL_PTR_HI = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WAIT  = 2'd1,
    SEQ_FETCH = 2'd2
  } seq_state_e;

  localparam int CTL_DEC_BIT = 7;
  localparam int CTL_WRQ_BIT = 2;
  localparam int SYNC_OFS    = 12;
  localparam int HDR_BYTES   = 4;
endpackage

// File: rtl/sbw_rst_sync.sv
module sbw_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/sbw_ring_ram.sv
module sbw_ring_ram #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sbw_decode_seq.sv
module sbw_decode_seq
  import sbw_pkg::*;
#(
  parameter int unsigned LATENCY = 225792
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       fetch_re,
  output logic [1:0] fetch_idx,
  output logic       cap_en,
  output logic [1:0] cap_idx,
  output logic       done
);
  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(LATENCY);
  localparam logic [2:0] LAST_STEP = 3'(HDR_BYTES);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [2:0]       step_q, step_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    step_d  = step_q;
    unique case (state_q)
      SEQ_WAIT: begin
        if (cnt_q == CNT_W'(1)) begin
          state_d = SEQ_FETCH;
          step_d  = 3'd0;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      SEQ_FETCH: begin
        if (step_q == LAST_STEP) state_d = SEQ_IDLE;
        else                     step_d  = step_q + 3'd1;
      end
      default: ;
    endcase
    if (start) begin
      state_d = SEQ_WAIT;
      cnt_d   = CNT_INIT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      step_q  <= step_d;
    end
  end

  assign fetch_re  = (state_q == SEQ_FETCH) && (step_q < LAST_STEP);
  assign fetch_idx = step_q[1:0];
  assign cap_en    = (state_q == SEQ_FETCH) && (step_q != 3'd0);
  assign cap_idx   = 2'(step_q - 3'd1);
  assign done      = (state_q == SEQ_FETCH) && (step_q == LAST_STEP);
endmodule

// File: rtl/sector_buf_writer.sv
module sector_buf_writer
  import sbw_pkg::*;
#(
  parameter int          BUF_AW     = 11,
  parameter int          OFS_W      = 12,
  parameter int          SECTOR_LEN = 2352,
  parameter int unsigned DECODE_LAT = 225792
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  input  logic              byte_valid,
  input  logic [OFS_W-1:0]  byte_ofs,
  input  logic [7:0]        byte_data,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_waddr,
  output logic [7:0]        buf_wdata,
  output logic [15:0]       wr_addr,
  output logic [15:0]       blk_ptr,
  output logic [31:0]       hdr_bytes,
  output logic              hdr_pend,
  output logic              dec_irq_n
);
  localparam logic [15:0]      BACK_STEP = 16'(SECTOR_LEN);
  localparam logic [OFS_W-1:0] SYNC_POS  = OFS_W'(SYNC_OFS);

  logic rst_q_n;
  logic de_q, wrq_q, de_d, wrq_d, ctl_en;
  logic [15:0] wa_q, wa_d, ptr_q, ptr_d;
  logic [HDR_BYTES-1:0][7:0] hdr_q, hdr_d;
  logic pend_q, pend_d, irq_n_q, irq_n_d;

  logic store_en, mon_en, is_sync, sync_start, ptr_hi_wr, dec_start;
  logic [OFS_W-1:0] mon_rel;
  logic fetch_re, cap_en, seq_done, done_eff;
  logic [1:0] fetch_idx, cap_idx;
  logic [BUF_AW-1:0] rd_addr;
  logic [7:0] rd_data;

  sbw_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign store_en   = byte_valid && de_q && wrq_q;
  assign mon_en     = byte_valid && de_q && !wrq_q;
  assign is_sync    = byte_valid && (byte_ofs == SYNC_POS);
  assign sync_start = is_sync && store_en;
  assign ptr_hi_wr  = reg_wr && (reg_sel == SEL_PTR_HI);
  assign dec_start  = sync_start || ptr_hi_wr;
  assign mon_rel    = byte_ofs - SYNC_POS;
  assign done_eff   = seq_done && !dec_start;
  assign rd_addr    = ptr_q[BUF_AW-1:0] + BUF_AW'(fetch_idx);

  sbw_decode_seq #(.LATENCY(DECODE_LAT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .start     (dec_start),
    .fetch_re  (fetch_re),
    .fetch_idx (fetch_idx),
    .cap_en    (cap_en),
    .cap_idx   (cap_idx),
    .done      (seq_done)
  );

  sbw_ring_ram #(.AW(BUF_AW)) u_ram (
    .clk   (clk),
    .we    (store_en),
    .waddr (wa_q[BUF_AW-1:0]),
    .wdata (byte_data),
    .re    (fetch_re),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // Control register
  always_comb begin
    ctl_en = reg_wr && (reg_sel == SEL_CTL);
    de_d   = reg_wdata[CTL_DEC_BIT];
    wrq_d  = reg_wdata[CTL_WRQ_BIT];
  end

  // Write address: register writes override the post-store increment
  always_comb begin
    wa_d = wa_q;
    if (store_en) begin
      wa_d[7:0]  = wa_q[7:0] + 8'd1;
      wa_d[15:8] = wa_q[15:8] + {7'd0, (wa_q[7:0] == 8'hFF)};
    end
    if (reg_wr && reg_sel == SEL_WA_LO) wa_d[7:0]  = reg_wdata;
    if (reg_wr && reg_sel == SEL_WA_HI) wa_d[15:8] = reg_wdata;
  end

  // Block pointer: a stored sync byte overrides a register write
  always_comb begin
    ptr_d = ptr_q;
    if (reg_wr && reg_sel == SEL_PTR_LO) ptr_d[7:0]  = reg_wdata;
    if (ptr_hi_wr)                       ptr_d[15:8] = reg_wdata;
    if (sync_start)                      ptr_d       = wa_q - BACK_STEP;
  end

  // Header registers: ring fetch has priority over monitor capture
  always_comb begin
    hdr_d = hdr_q;
    if (mon_en && (mon_rel < OFS_W'(HDR_BYTES))) hdr_d[mon_rel[1:0]] = byte_data;
    if (cap_en)                                  hdr_d[cap_idx]      = rd_data;
  end

  // Status flags: a new sync or start wins over a completion
  always_comb begin
    pend_d  = pend_q;
    irq_n_d = irq_n_q;
    if (done_eff) begin
      pend_d  = 1'b0;
      irq_n_d = 1'b0;
    end
    if (is_sync)   pend_d  = 1'b1;
    if (dec_start) irq_n_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      de_q    <= 1'b0;
      wrq_q   <= 1'b0;
      wa_q    <= '0;
      ptr_q   <= '0;
      hdr_q   <= '0;
      pend_q  <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      if (ctl_en) begin
        de_q  <= de_d;
        wrq_q <= wrq_d;
      end
      wa_q    <= wa_d;
      ptr_q   <= ptr_d;
      hdr_q   <= hdr_d;
      pend_q  <= pend_d;
      irq_n_q <= irq_n_d;
    end
  end

  assign buf_we    = store_en;
  assign buf_waddr = wa_q[BUF_AW-1:0];
  assign buf_wdata = byte_data;
  assign wr_addr   = wa_q;
  assign blk_ptr   = ptr_q;
  assign hdr_bytes = hdr_q;
  assign hdr_pend  = pend_q;
  assign dec_irq_n = irq_n_q;
endmodule

// File: rtl/sector_buf_writer_chk.sv
module sector_buf_writer_chk #(
  parameter int OFS_W      = 12,
  parameter int SECTOR_LEN = 2352
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             byte_valid,
  input logic [OFS_W-1:0] byte_ofs,
  input logic             reg_wr,
  input logic [2:0]       reg_sel,
  input logic             buf_we,
  input logic [15:0]      wr_addr,
  input logic [15:0]      blk_ptr,
  input logic             hdr_pend,
  input logic             dec_irq_n,
  input logic             de_q,
  input logic             wrq_q
);
  localparam logic [15:0] BACK_STEP = 16'(SECTOR_LEN);

  AST_WA_ADVANCE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (buf_we && !reg_wr) |=> (wr_addr == $past(wr_addr) + 16'd1)); // R2

  AST_WA_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!buf_we && !reg_wr) |=> $stable(wr_addr)); // R2

  AST_SYNC_PEND: assert property (@(posedge clk) disable iff (!rst_q_n)
    (byte_valid && byte_ofs == OFS_W'(12)) |=> hdr_pend); // R3

  AST_PTR_BACK: assert property (@(posedge clk) disable iff (!rst_q_n)
    (buf_we && byte_ofs == OFS_W'(12)) |=> (blk_ptr == $past(wr_addr) - BACK_STEP && dec_irq_n)); // R4

  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(hdr_pend) |-> !dec_irq_n); // R5

  AST_MON_NO_STORE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (byte_valid && de_q && !wrq_q) |-> !buf_we); // R7

  AST_PTR_START: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_wr && reg_sel == 3'd4) |=> dec_irq_n); // R8
endmodule

bind sector_buf_writer sector_buf_writer_chk #(
  .OFS_W      (OFS_W),
  .SECTOR_LEN (SECTOR_LEN)
) u_chk (.*);

// File: tb/sector_buf_writer_test.sv
module sector_buf_writer_test;
  localparam int AW  = 11;
  localparam int OW  = 12;
  localparam int LAT = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr;
  logic [2:0] reg_sel;
  logic [7:0] reg_wdata;
  logic byte_valid;
  logic [OW-1:0] byte_ofs;
  logic [7:0] byte_data;
  logic buf_we;
  logic [AW-1:0] buf_waddr;
  logic [7:0] buf_wdata;
  logic [15:0] wr_addr, blk_ptr;
  logic [31:0] hdr_bytes;
  logic hdr_pend, dec_irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit all_done = 0;

  always #10 clk = ~clk;

  sector_buf_writer #(
    .BUF_AW(AW), .OFS_W(OW), .SECTOR_LEN(2352), .DECODE_LAT(LAT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .byte_valid(byte_valid), .byte_ofs(byte_ofs),
    .byte_data(byte_data), .buf_we(buf_we), .buf_waddr(buf_waddr),
    .buf_wdata(buf_wdata), .wr_addr(wr_addr), .blk_ptr(blk_ptr),
    .hdr_bytes(hdr_bytes), .hdr_pend(hdr_pend), .dec_irq_n(dec_irq_n)
  );

  // {control[7:0], data[7:0], expected store}
  localparam int NV = 8;
  localparam logic [16:0] VEC [NV] = '{
    {8'h84, 8'hA1, 1'b1}, {8'h80, 8'hA2, 1'b0}, {8'h04, 8'hA3, 1'b0},
    {8'h00, 8'hA4, 1'b0}, {8'hFF, 8'hA5, 1'b1}, {8'h7B, 8'hA6, 1'b0},
    {8'h85, 8'hA7, 1'b1}, {8'h8C, 8'hA8, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [7:0] val);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic put_byte(input int ofs, input logic [7:0] val, input logic exp_we);
    byte_valid = 1'b1; byte_ofs = OW'(ofs); byte_data = val;
    #1;
    chk("R1 store enable", {31'd0, buf_we}, {31'd0, exp_we});
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!all_done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [15:0] exp_wa;
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = '0; reg_wdata = '0;
    byte_valid = 1'b0; byte_ofs = '0; byte_data = '0;
    step(3);
    rst_n = 1'b1;
    step(3);

    // R10 reset state
    chk("R10 wr_addr", {16'd0, wr_addr}, 32'd0);
    chk("R10 blk_ptr", {16'd0, blk_ptr}, 32'd0);
    chk("R10 hdr", hdr_bytes, 32'd0);
    chk("R10 pend", {31'd0, hdr_pend}, 32'd0);
    chk("R10 irq_n", {31'd0, dec_irq_n}, 32'd1);

    // R1/R2 table walk over control settings
    exp_wa = 16'd0;
    for (int i = 0; i < NV; i++) begin
      wr_reg(3'd0, VEC[i][16:9]);
      byte_valid = 1'b1; byte_ofs = OW'(20); byte_data = VEC[i][8:1];
      #1;
      chk("R1 store gate", {31'd0, buf_we}, {31'd0, VEC[i][0]});
      if (VEC[i][0]) begin
        chk("R1 index", {21'd0, buf_waddr}, {21'd0, exp_wa[AW-1:0]});
        chk("R1 data", {24'd0, buf_wdata}, {24'd0, VEC[i][8:1]});
      end
      @(negedge clk);
      byte_valid = 1'b0;
      exp_wa = exp_wa + {15'd0, VEC[i][0]};
      chk("R2 cursor", {16'd0, wr_addr}, {16'd0, exp_wa});
    end

    // R2 carry into high byte
    wr_reg(3'd0, 8'h84);
    wr_reg(3'd1, 8'hFF); wr_reg(3'd2, 8'h00);
    put_byte(30, 8'h01, 1'b1);
    chk("R2 carry", {16'd0, wr_addr}, 32'h0100);

    // R4/R5/R6 decode from sync byte
    wr_reg(3'd1, 8'h10); wr_reg(3'd2, 8'h00);
    put_byte(100, 8'hAA, 1'b1); put_byte(101, 8'hBB, 1'b1);
    put_byte(102, 8'hCC, 1'b1); put_byte(103, 8'hDD, 1'b1);
    wr_reg(3'd1, 8'h40); wr_reg(3'd2, 8'h09);
    put_byte(12, 8'h77, 1'b1);
    chk("R4 pointer", {16'd0, blk_ptr}, 32'h0010);
    chk("R3 pend set", {31'd0, hdr_pend}, 32'd1);
    chk("R4 irq_n high", {31'd0, dec_irq_n}, 32'd1);
    step(LAT + 4);
    chk("R5 pend before", {31'd0, hdr_pend}, 32'd1);
    chk("R5 irq_n before", {31'd0, dec_irq_n}, 32'd1);
    step(1);
    chk("R5 pend done", {31'd0, hdr_pend}, 32'd0);
    chk("R5 irq_n done", {31'd0, dec_irq_n}, 32'd0);
    chk("R6 header", hdr_bytes, 32'hDDCCBBAA);

    // R6/R8 pointer-write decode with ring wrap
    wr_reg(3'd1, 8'hFE); wr_reg(3'd2, 8'h07);
    put_byte(200, 8'h11, 1'b1); put_byte(201, 8'h22, 1'b1);
    put_byte(202, 8'h33, 1'b1); put_byte(203, 8'h44, 1'b1);
    wr_reg(3'd3, 8'hFE);
    wr_reg(3'd4, 8'h07);
    chk("R8 irq_n high", {31'd0, dec_irq_n}, 32'd1);
    chk("R8 pointer", {16'd0, blk_ptr}, 32'h07FE);
    step(LAT + 4);
    chk("R8 irq_n before", {31'd0, dec_irq_n}, 32'd1);
    step(1);
    chk("R8 irq_n done", {31'd0, dec_irq_n}, 32'd0);
    chk("R6 wrap header", hdr_bytes, 32'h44332211);

    // R9 restart while pending
    wr_reg(3'd1, 8'h40); wr_reg(3'd2, 8'h09);
    put_byte(12, 8'h55, 1'b1);
    step(6);
    wr_reg(3'd1, 8'h40);
    put_byte(12, 8'h56, 1'b1);
    step(LAT - 3);
    chk("R9 first completion dropped", {31'd0, hdr_pend}, 32'd1);
    chk("R9 irq_n held", {31'd0, dec_irq_n}, 32'd1);
    step(7);
    chk("R9 pend before", {31'd0, hdr_pend}, 32'd1);
    step(1);
    chk("R9 pend done", {31'd0, hdr_pend}, 32'd0);
    chk("R9 header", hdr_bytes, 32'hDDCCBBAA);

    // R7 monitor mode
    wr_reg(3'd0, 8'h80);
    put_byte(12, 8'h5A, 1'b0); put_byte(13, 8'h6B, 1'b0);
    put_byte(14, 8'h7C, 1'b0); put_byte(15, 8'h8D, 1'b0);
    put_byte(16, 8'h9E, 1'b0);
    chk("R7 cursor held", {16'd0, wr_addr}, 32'h0941);
    chk("R7 header direct", hdr_bytes, 32'h8D7C6B5A);
    chk("R3 pend in monitor", {31'd0, hdr_pend}, 32'd1);
    step(LAT + 6);
    chk("R7 no decode pend", {31'd0, hdr_pend}, 32'd1);
    chk("R7 no decode irq_n", {31'd0, dec_irq_n}, 32'd0);

    all_done = 1;
    finish_run();
  end
endmodule